// File: doc/BRIEF.md
# Receive Ones-Density Alarm

This block watches the recovered bit stream on the receive side of a T1 line. It raises an alarm when the line carries too few ones for the far-end repeaters and the local clock recovery to stay locked. Each data bit arrives together with a valid strobe at the line bit rate. Cycles with the strobe low are gaps in the stream and change nothing.

Two criteria run side by side. The first is a run counter that trips once the current stretch of zeros grows longer than a set limit (15 bits by default). The second is a window that slides over the most recent bits (192 by default) and trips when it holds fewer ones than a set minimum (24 by default, which is one in eight). The window check stays silent until a full window of bits has arrived since reset.

The alarm is the OR of the two criteria. It is reported three ways for an alarm status bank: a real-time level, a one-cycle pulse on each rising edge of that level, and a sticky bit. The sticky bit stays set until a status read clears it.

Top module: `rx_ones_density_mon`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `viol_lvl`, `viol_evt` and `viol_sticky` are 0. The zero-run count and the window both start empty.
- R2: In the clock after the valid bit that makes the current zero run 16 bits long (one more than RUN_LIMIT), `viol_lvl` is 1. A run of exactly 15 zeros does not raise it.
- R3: A valid bit with `bit_data` = 1 restarts the zero run at 0. If the window criterion is not failing, `viol_lvl` is 0 in the next clock.
- R4: Until WIN_LEN (192) valid bits have been received since reset, the density criterion does not raise `viol_lvl`, however sparse the ones are.
- R5: Once the window is full, the density criterion fails exactly when the last 192 valid bits contain fewer than 24 ones. A window with exactly 24 ones passes.
- R6: The window slides. Each new valid bit enters it and the oldest bit leaves it, so the density failure clears once enough ones have arrived.
- R7: A cycle with `bit_vld` = 0 leaves both criteria and `viol_lvl` unchanged, whatever the value on `bit_data`.
- R8: `viol_evt` is 1 for exactly one clock, in the clock in which `viol_lvl` has just gone from 0 to 1, and at no other time.
- R9: `viol_sticky` becomes 1 in the clock after `viol_evt`. It stays 1 until a clock in which `stat_rd` is 1 and `viol_evt` is 0, and it is 0 after that clock. When a read and an event fall in the same clock, the event wins and the bit stays set.
- R10: `viol_lvl` is the OR of the two criteria. The density failure alone raises it, even while no zero run exceeds the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Strobe: `bit_data` carries a line bit this cycle |
| bit_data | input | 1 | Recovered receive bit |
| stat_rd | input | 1 | Status read; clears the sticky bit |
| viol_lvl | output | 1 | Real-time violation level |
| viol_evt | output | 1 | One-cycle pulse on the rising edge of the level |
| viol_sticky | output | 1 | Latched violation, cleared on read |

## Verification
The bench aims at both edges of each limit. It sends runs of 15 and 16 zeros, so a design off by one either alarms on a legal run or misses the violation. It sends a window of exactly 24 ones and a sparse stream over the first 191 bits: a comparison with the wrong bound, or a window that judges before it is full, raises a false alarm. Idle cycles carrying ones and zeros catch a counter that ignores the strobe. The bench also turns a failing window back into a healthy one, which catches a window that never drops its oldest bit, and issues a read in the same cycle as an event, which catches a sticky bit that gives the read priority and loses the event.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   typedef struct packed {
      logic run_fail;
      logic dens_fail;
   } rxd_verdict_t;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/rxd_zero_run.sv
module rxd_zero_run #(
   parameter int unsigned RUN_LIMIT = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_data,
   output logic run_fail
);
   import rxd_pkg::*;

   localparam int unsigned SAT = RUN_LIMIT + 1;
   localparam int unsigned W   = cnt_bits(SAT);
   localparam logic [W-1:0] SAT_V = W'(SAT);

   logic [W-1:0] run_q;

   // Count saturates one past the limit; any received one restarts it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_vld) begin
         if (bit_data)
            run_q <= '0;
         else if (run_q != SAT_V)
            run_q <= run_q + 1'b1;
      end
   end

   assign run_fail = (run_q == SAT_V);

endmodule

// File: rtl/rxd_density_win.sv
module rxd_density_win #(
   parameter int unsigned WIN_LEN  = 192,
   parameter int unsigned MIN_ONES = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_data,
   output logic dens_fail
);
   import rxd_pkg::*;

   localparam int unsigned CW = cnt_bits(WIN_LEN);
   localparam logic [CW-1:0] FULL_V = CW'(WIN_LEN);
   localparam logic [CW-1:0] MIN_V  = CW'(MIN_ONES);

   logic [WIN_LEN-1:0] win_q;
   logic [CW-1:0]      fill_q;
   logic [CW-1:0]      ones_q;
   logic               full;
   logic               drop_one;

   assign full     = (fill_q == FULL_V);
   assign drop_one = full & win_q[WIN_LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
         ones_q <= '0;
      end else if (bit_vld) begin
         win_q  <= {win_q[WIN_LEN-2:0], bit_data};
         if (!full)
            fill_q <= fill_q + 1'b1;
         ones_q <= ones_q + CW'(bit_data) - CW'(drop_one);
      end
   end

   assign dens_fail = full & (ones_q < MIN_V);

endmodule

// File: rtl/rxd_alarm_latch.sv
module rxd_alarm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic stat_rd,
   output logic evt,
   output logic sticky
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         sticky <= 1'b0;
      end else begin
         lvl_q  <= lvl;
         // A new event beats a read arriving in the same cycle.
         sticky <= evt | (sticky & ~stat_rd);
      end
   end

   assign evt = lvl & ~lvl_q;

endmodule

// File: rtl/rx_ones_density_mon.sv
module rx_ones_density_mon #(
   parameter int unsigned RUN_LIMIT = 15,
   parameter int unsigned WIN_LEN   = 192,
   parameter int unsigned MIN_ONES  = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_data,
   input  logic stat_rd,
   output logic viol_lvl,
   output logic viol_evt,
   output logic viol_sticky
);
   import rxd_pkg::*;

   generate
      if (RUN_LIMIT < 1) begin : g_bad_run
         $error("RUN_LIMIT must be at least 1");
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (MIN_ONES > WIN_LEN) begin : g_bad_min
         $error("MIN_ONES cannot exceed WIN_LEN");
      end
   endgenerate

   rxd_verdict_t verdict;

   rxd_zero_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (bit_vld),
      .bit_data (bit_data),
      .run_fail (verdict.run_fail)
   );

   rxd_density_win #(.WIN_LEN(WIN_LEN), .MIN_ONES(MIN_ONES)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (bit_vld),
      .bit_data  (bit_data),
      .dens_fail (verdict.dens_fail)
   );

   assign viol_lvl = verdict.run_fail | verdict.dens_fail;

   rxd_alarm_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (viol_lvl),
      .stat_rd (stat_rd),
      .evt     (viol_evt),
      .sticky  (viol_sticky)
   );

endmodule

// File: rtl/rxd_guard_chk.sv
module rxd_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_vld,
   input logic bit_data,
   input logic stat_rd,
   input logic viol_lvl,
   input logic viol_evt,
   input logic viol_sticky,
   input logic run_fail
);
   AST_EVT_NEEDS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      viol_evt |-> viol_lvl); // R8
   AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_evt |=> !viol_evt); // R8
   AST_STICKY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      viol_evt |=> viol_sticky); // R9
   AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !viol_evt) |=> !viol_sticky); // R9
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(viol_lvl)); // R7
   AST_ONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && bit_data) |=> !run_fail); // R3
   AST_RUN_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_fail) |-> $past(bit_vld && !bit_data)); // R2
endmodule

bind rx_ones_density_mon rxd_guard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_vld     (bit_vld),
   .bit_data    (bit_data),
   .stat_rd     (stat_rd),
   .viol_lvl    (viol_lvl),
   .viol_evt    (viol_evt),
   .viol_sticky (viol_sticky),
   .run_fail    (verdict.run_fail)
);

// File: tb/sim_rx_ones_density_mon.sv
`timescale 1ns/1ps
module sim_rx_ones_density_mon;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_data = 1'b0;
   logic stat_rd = 1'b0;
   logic viol_lvl, viol_evt, viol_sticky;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rx_ones_density_mon u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_vld     (bit_vld),
      .bit_data    (bit_data),
      .stat_rd     (stat_rd),
      .viol_lvl    (viol_lvl),
      .viol_evt    (viol_evt),
      .viol_sticky (viol_sticky)
   );

   typedef struct {
      bit    lvl;
      bit    evt;
      bit    stk;
      string tag;
   } item_t;

   item_t sb[$];

   // Reference model state
   int hist[$];
   int m_run = 0;
   bit m_lvl = 0, m_evt = 0, m_stk = 0;

   task automatic chk(input logic act, input bit exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", what, act, exp);
      end
   endtask

   task automatic send(input bit vld, input bit d, input bit rd, input string tag);
      int ones;
      bit full, nl;
      @(negedge clk);
      bit_vld = vld; bit_data = d; stat_rd = rd;
      m_stk = m_evt | (m_stk & ~rd);
      if (vld) begin
         hist.push_back(int'(d));
         if (hist.size() > 192) void'(hist.pop_front());
         if (d) m_run = 0;
         else if (m_run < 16) m_run++;
      end
      full = (hist.size() == 192);
      ones = 0;
      foreach (hist[i]) ones += hist[i];
      nl = (m_run > 15) || (full && ones < 24);
      m_evt = nl && !m_lvl;
      m_lvl = nl;
      sb.push_back('{m_lvl, m_evt, m_stk, tag});
   endtask

   task automatic do_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b0; bit_vld = 1'b0; bit_data = 1'b0; stat_rd = 1'b0;
      hist.delete(); m_run = 0; m_lvl = 0; m_evt = 0; m_stk = 0;
      repeat (3) @(negedge clk);
      chk(viol_lvl, 0, "R1 level in reset");
      chk(viol_evt, 0, "R1 event in reset");
      chk(viol_sticky, 0, "R1 sticky in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(viol_lvl, 0, "R1 level after reset");
      chk(viol_sticky, 0, "R1 sticky after reset");
   endtask

   // Monitor: compares each queued expectation after the clock edge.
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            chk(viol_lvl, it.lvl, {it.tag, " level"});
            chk(viol_evt, it.evt, {it.tag, " event"});
            chk(viol_sticky, it.stk, {it.tag, " sticky"});
         end
      end
   end

   initial begin
      #(8 * 200000);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      do_reset();

      // R4/R5: one in sixteen ones; silent until window full, then fails.
      for (int i = 0; i < 192; i++)
         send(1, (i % 16) == 15, 0, (i < 191) ? "R4 window not yet full" : "R5 sparse full window");
      repeat (3) send(0, 0, 0, "R8 event done");
      do_reset();

      // R2, R8, R9, R3
      for (int i = 0; i < 15; i++) send(1, 0, 0, "R2 fifteen zeros legal");
      send(1, 0, 0, "R2 sixteenth zero");
      send(0, 0, 1, "R9 read with event");
      send(0, 0, 0, "R9 sticky held");
      send(1, 1, 0, "R3 one clears run");
      send(0, 0, 0, "R3 level stays low");
      send(0, 0, 1, "R9 read clears");
      send(0, 0, 0, "R9 cleared");

      // R7: idle cycles with any data change nothing
      for (int i = 0; i < 10; i++) send(1, 0, 0, "R7 zeros before gap");
      for (int i = 0; i < 20; i++) send(0, 1, 0, "R7 invalid ones");
      for (int i = 0; i < 20; i++) send(0, 0, 0, "R7 invalid zeros");
      for (int i = 0; i < 6; i++) send(1, 0, 0, "R7 run resumes");
      send(1, 1, 0, "R3 one ends run");
      do_reset();

      // R5 boundary: exactly one in eight holds
      for (int i = 0; i < 240; i++) send(1, (i % 8) == 7, 0, "R5 exact minimum holds");
      // R10: one in nine, runs short, density alone fails
      for (int i = 0; i < 216; i++) send(1, (i % 9) == 8, 0, "R10 density alone");
      // R6: dense ones slide old bits out
      for (int i = 0; i < 48; i++) send(1, 1, 0, "R6 window slides");
      send(0, 0, 1, "R6 read");
      send(0, 0, 0, "R6 settled");

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule